// File: doc/BRIEF.md
# Multi-Queue Transmit Channel Scheduler

This block tracks sixteen circular transmit rings held in host memory and hands their entries to eight output channels. The host supplies each ring's producer index. The scheduler owns the consumer index. A per-ring configuration word ties the ring to one channel, marks it live, and selects plain in-order service or acknowledgement-tracking service. Any number of rings may feed one channel, but each ring feeds exactly one.

In every cycle, each enabled channel looks at the live, non-empty rings bound to it. It picks one of them in rotating order and presents a request that carries the ring number and its consumer index. When the downstream engine accepts the request, the consumer index of that ring moves forward by one and wraps at the end of the ring. Channels are independent, so several may be granted in the same cycle. Configuration words and the per-ring empty flags are written with embedded per-bit write masks, so software can change one field without a read-modify-write. A combinational read port returns any ring's consumer index and configuration word.

Top module: `txq_sched`

## Requirements
- R1: After reset no request is valid, every ring's consumer index and configuration word read 0, and all sixteen empty flags read 1.
- R2: A configuration write updates bit k (k = 0..9) only when bit k+10 of the written word is 1. Unmasked bits keep their value, and the word is unchanged in any cycle without a write.
- R3: A ring is offered on channel c only when its configuration bit 0 (live) is 1, bits 4:1 equal c, and its empty flag is 0. The request then carries the ring number and the ring's consumer index.
- R4: A channel whose bit in the 8-bit channel-enable register is 0 presents no request.
- R5: A ring with bit 8 (acknowledgement tracking) set is offered only while bit 5 (window space left) is also 1.
- R6: Each accepted request advances that ring's consumer index by exactly one, modulo 256 (255 goes to 0).
- R7: Among rings that share a channel, grants rotate in ascending ring order, starting after the last ring granted (ring 0 first after reset). A channel gives at most one grant per cycle.
- R8: Different channels are scheduled independently, and two channels can both be granted in one cycle.
- R9: Whenever a ring's producer or consumer index changes, its empty flag becomes 1 exactly when the two indexes are equal.
- R10: An empty-flag write sets flag q to bit q of the word only where bit q+16 is 1. Flags left unmasked keep their value, and a forced flag gates requests like a computed one.
- R11: A ring whose channel field is 8 or more is never offered on any channel.
- R12: A host write of a consumer index takes priority over an advance of the same ring in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_en_we | input | 1 | Write strobe for the channel-enable register |
| chan_en_wdata | input | 8 | One enable bit per channel |
| wrptr_we | input | 1 | Write strobe for a producer index |
| wrptr_qid | input | 4 | Ring selected for the producer-index write |
| wrptr_wdata | input | 8 | New producer index |
| rdptr_we | input | 1 | Write strobe for a consumer index |
| rdptr_qid | input | 4 | Ring selected for the consumer-index write |
| rdptr_wdata | input | 8 | New consumer index |
| cfg_we | input | 1 | Write strobe for a configuration word |
| cfg_qid | input | 4 | Ring selected for the configuration write |
| cfg_wdata | input | 20 | Bits 19:10 are per-bit masks for value bits 9:0 |
| empty_we | input | 1 | Write strobe for the empty flags |
| empty_wdata | input | 32 | Bits 31:16 are masks, bits 15:0 are flag values |
| req_valid | output | 8 | Request present, one bit per channel |
| req_ready | input | 8 | Request accepted, one bit per channel |
| req_qid | output | 32 | Ring number, 4 bits per channel |
| req_idx | output | 64 | Consumer index, 8 bits per channel |
| rd_qid | input | 4 | Ring selected for readback |
| rd_rdptr | output | 8 | Consumer index of the selected ring |
| rd_cfg | output | 10 | Configuration word of the selected ring |
| empty_flags | output | 16 | Current empty flag of every ring |

## Verification
The case that is hardest to reach from the ports is a host consumer-index write that lands in the same cycle as an accept on the same ring. The bench holds a ring's request steady, then raises that channel's ready and the index write on one edge. It expects the scoreboard to record the grant while the written index survives. Rotation across three rings on one channel and a wrap from 255 to 0 are set up by writing the indexes directly. Every accepted request is matched against an ordered list of expected grants.

// File: rtl/txq_pkg.sv
package txq_pkg;
  localparam int CFG_W      = 10;
  localparam int CFG_WR_W   = 2 * CFG_W;
  localparam int CFG_LIVE   = 0;
  localparam int CFG_CH_LO  = 1;
  localparam int CFG_CH_W   = 4;
  localparam int CFG_WIN    = 5;
  localparam int CFG_TRACK  = 8;

  // Merge a masked write: upper half enables lower half bit by bit.
  function automatic logic [CFG_W-1:0] cfg_merge(input logic [CFG_W-1:0] cur,
                                                 input logic [CFG_WR_W-1:0] wr);
    logic [CFG_W-1:0] msk;
    msk = wr[CFG_WR_W-1:CFG_W];
    return (cur & ~msk) | (wr[CFG_W-1:0] & msk);
  endfunction
endpackage

// File: rtl/txq_ring_state.sv
module txq_ring_state
  import txq_pkg::*;
#(
  parameter int PTR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wp_we,
  input  logic [PTR_W-1:0] wp_wdata,
  input  logic             rp_we,
  input  logic [PTR_W-1:0] rp_wdata,
  input  logic             cfg_we,
  input  logic [CFG_WR_W-1:0] cfg_wdata,
  input  logic             ef_we,
  input  logic             ef_wval,
  input  logic             adv,
  output logic [PTR_W-1:0] wrptr,
  output logic [PTR_W-1:0] rdptr,
  output logic [CFG_W-1:0] cfg,
  output logic             empty
);
  logic [PTR_W-1:0] wp_n, rp_n;
  logic [CFG_W-1:0] cfg_n;
  logic             empty_n;
  logic             ptr_en, empty_en;

  always_comb begin
    wp_n     = wp_we ? wp_wdata : wrptr;
    if (rp_we)    rp_n = rp_wdata;
    else if (adv) rp_n = rdptr + PTR_W'(1);
    else          rp_n = rdptr;
    cfg_n    = cfg_merge(cfg, cfg_wdata);
    ptr_en   = wp_we | rp_we | adv;
    empty_en = ptr_en | ef_we;
    empty_n  = empty;
    if (ptr_en) empty_n = (wp_n == rp_n);
    if (ef_we)  empty_n = ef_wval;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrptr <= '0;
      rdptr <= '0;
      cfg   <= '0;
      empty <= 1'b1;
    end else begin
      if (ptr_en)   wrptr <= wp_n;
      if (ptr_en)   rdptr <= rp_n;
      if (cfg_we)   cfg   <= cfg_n;
      if (empty_en) empty <= empty_n;
    end
  end

  AST_RDPTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !rp_we) |=> rdptr == $past(rdptr) + PTR_W'(1)); // R6
  AST_HOST_RD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    rp_we |=> rdptr == $past(rp_wdata)); // R12
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(cfg)); // R2
  AST_EMPTY_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    ((wp_we || rp_we || adv) && !ef_we) |=> empty == (wrptr == rdptr)); // R9
endmodule

// File: rtl/txq_rr_arb.sv
module txq_rr_arb #(
  parameter int N  = 16,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req_i,
  input  logic          accept_i,
  output logic          valid_o,
  output logic [IW-1:0] gnt_o
);
  logic [IW-1:0] last_q;

  always_comb begin
    valid_o = 1'b0;
    gnt_o   = last_q;
    for (int off = 1; off <= N; off++) begin
      int idx;
      idx = (int'(last_q) + off) % N;
      if (!valid_o && req_i[idx]) begin
        valid_o = 1'b1;
        gnt_o   = IW'(idx);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        last_q <= IW'(N - 1);
    else if (accept_i) last_q <= gnt_o;
  end

  AST_GNT_REQUESTED: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> req_i[gnt_o]); // R7
  AST_VALID_IFF_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o == (|req_i)); // R7
endmodule

// File: rtl/txq_sched.sv
module txq_sched
  import txq_pkg::*;
#(
  parameter int NQ    = 16,
  parameter int NCH   = 8,
  parameter int PTR_W = 8,
  localparam int QW   = $clog2(NQ)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               chan_en_we,
  input  logic [NCH-1:0]     chan_en_wdata,
  input  logic               wrptr_we,
  input  logic [QW-1:0]      wrptr_qid,
  input  logic [PTR_W-1:0]   wrptr_wdata,
  input  logic               rdptr_we,
  input  logic [QW-1:0]      rdptr_qid,
  input  logic [PTR_W-1:0]   rdptr_wdata,
  input  logic               cfg_we,
  input  logic [QW-1:0]      cfg_qid,
  input  logic [CFG_WR_W-1:0] cfg_wdata,
  input  logic               empty_we,
  input  logic [2*NQ-1:0]    empty_wdata,
  output logic [NCH-1:0]     req_valid,
  input  logic [NCH-1:0]     req_ready,
  output logic [NCH*QW-1:0]  req_qid,
  output logic [NCH*PTR_W-1:0] req_idx,
  input  logic [QW-1:0]      rd_qid,
  output logic [PTR_W-1:0]   rd_rdptr,
  output logic [CFG_W-1:0]   rd_cfg,
  output logic [NQ-1:0]      empty_flags
);
  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_sync;
  logic       rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_sn = rst_sync[1];

  logic [NCH-1:0] chan_en_q;
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)         chan_en_q <= '0;
    else if (chan_en_we) chan_en_q <= chan_en_wdata;
  end

  logic [PTR_W-1:0] q_wr  [NQ];
  logic [PTR_W-1:0] q_rd  [NQ];
  logic [CFG_W-1:0] q_cfg [NQ];
  logic [NQ-1:0]    q_empty;
  logic [NQ-1:0]    q_adv;
  logic [NQ-1:0]    q_base;
  logic [NQ-1:0]    req_vec [NCH];
  logic [QW-1:0]    gnt     [NCH];
  logic [NCH-1:0]   accept;

  for (genvar q = 0; q < NQ; q++) begin : g_ring
    txq_ring_state #(.PTR_W(PTR_W)) u_ring (
      .clk      (clk),
      .rst_n    (rst_sn),
      .wp_we    (wrptr_we && (wrptr_qid == QW'(q))),
      .wp_wdata (wrptr_wdata),
      .rp_we    (rdptr_we && (rdptr_qid == QW'(q))),
      .rp_wdata (rdptr_wdata),
      .cfg_we   (cfg_we && (cfg_qid == QW'(q))),
      .cfg_wdata(cfg_wdata),
      .ef_we    (empty_we && empty_wdata[NQ+q]),
      .ef_wval  (empty_wdata[q]),
      .adv      (q_adv[q]),
      .wrptr    (q_wr[q]),
      .rdptr    (q_rd[q]),
      .cfg      (q_cfg[q]),
      .empty    (q_empty[q])
    );
    assign q_base[q] = q_cfg[q][CFG_LIVE] && !q_empty[q] &&
                       (!q_cfg[q][CFG_TRACK] || q_cfg[q][CFG_WIN]);
  end

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      for (int q = 0; q < NQ; q++) begin
        req_vec[c][q] = q_base[q] && chan_en_q[c] &&
                        (q_cfg[q][CFG_CH_LO +: CFG_CH_W] == CFG_CH_W'(c));
      end
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    txq_rr_arb #(.N(NQ), .IW(QW)) u_arb (
      .clk     (clk),
      .rst_n   (rst_sn),
      .req_i   (req_vec[c]),
      .accept_i(accept[c]),
      .valid_o (req_valid[c]),
      .gnt_o   (gnt[c])
    );
    assign accept[c]                = req_valid[c] && req_ready[c];
    assign req_qid[c*QW +: QW]       = gnt[c];
    assign req_idx[c*PTR_W +: PTR_W] = q_rd[gnt[c]];

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_sn)
      !chan_en_q[c] |-> !req_valid[c]); // R4
    AST_REQ_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_sn)
      req_valid[c] |-> (q_cfg[gnt[c]][CFG_LIVE] && !q_empty[gnt[c]] &&
                        q_cfg[gnt[c]][CFG_CH_LO +: CFG_CH_W] == CFG_CH_W'(c))); // R3
    AST_TRACK_WINDOW: assert property (@(posedge clk) disable iff (!rst_sn)
      (req_valid[c] && q_cfg[gnt[c]][CFG_TRACK]) |-> q_cfg[gnt[c]][CFG_WIN]); // R5
  end

  always_comb begin
    q_adv = '0;
    for (int c = 0; c < NCH; c++) begin
      for (int q = 0; q < NQ; q++) begin
        if (accept[c] && gnt[c] == QW'(q)) q_adv[q] = 1'b1;
      end
    end
  end

  assign rd_rdptr    = q_rd[rd_qid];
  assign rd_cfg      = q_cfg[rd_qid];
  assign empty_flags = q_empty;

  AST_ONE_ADV_SOURCE: assert property (@(posedge clk) disable iff (!rst_sn)
    $countones(accept) >= $countones(q_adv)); // R8
endmodule

// File: tb/txq_sched_tb.sv
module txq_sched_tb;
  localparam int NQ = 16, NCH = 8, PW = 8, QW = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n;
  logic chan_en_we; logic [NCH-1:0] chan_en_wdata;
  logic wrptr_we; logic [QW-1:0] wrptr_qid; logic [PW-1:0] wrptr_wdata;
  logic rdptr_we; logic [QW-1:0] rdptr_qid; logic [PW-1:0] rdptr_wdata;
  logic cfg_we; logic [QW-1:0] cfg_qid; logic [19:0] cfg_wdata;
  logic empty_we; logic [31:0] empty_wdata;
  logic [NCH-1:0] req_valid, req_ready;
  logic [NCH*QW-1:0] req_qid;
  logic [NCH*PW-1:0] req_idx;
  logic [QW-1:0] rd_qid;
  logic [PW-1:0] rd_rdptr;
  logic [9:0] rd_cfg;
  logic [NQ-1:0] empty_flags;

  txq_sched u_dut (.*);

  int checks = 0, fails = 0;
  bit mon_on = 1'b0;

  typedef struct { int ch; int q; int idx; string tag; } exp_t;
  exp_t sb[$];

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick; @(posedge clk); #1; endtask

  task automatic push(input int ch, input int q, input int idx, input string tag);
    exp_t e; e.ch = ch; e.q = q; e.idx = idx; e.tag = tag; sb.push_back(e);
  endtask

  // Monitor: every accepted request is compared with the scoreboard front.
  always @(negedge clk) begin
    if (mon_on) begin
      for (int c = 0; c < NCH; c++) begin
        if (req_valid[c] && req_ready[c]) begin
          checks++;
          if (sb.size() == 0) begin
            fails++;
            $display("FAIL R7 unexpected grant ch=%0d q=%0d expected=none", c, req_qid[c*QW +: QW]);
          end else begin
            exp_t e;
            e = sb.pop_front();
            if (e.ch != c || e.q != int'(req_qid[c*QW +: QW]) || e.idx != int'(req_idx[c*PW +: PW])) begin
              fails++;
              $display("FAIL %s actual=ch%0d/q%0d/i%0d expected=ch%0d/q%0d/i%0d", e.tag,
                       c, req_qid[c*QW +: QW], req_idx[c*PW +: PW], e.ch, e.q, e.idx);
            end
          end
        end
      end
    end
  end

  task automatic set_cfg(input int q, input logic [19:0] w);
    cfg_qid = QW'(q); cfg_wdata = w; cfg_we = 1'b1; tick; cfg_we = 1'b0;
  endtask
  task automatic set_wr(input int q, input int v);
    wrptr_qid = QW'(q); wrptr_wdata = PW'(v); wrptr_we = 1'b1; tick; wrptr_we = 1'b0;
  endtask
  task automatic set_rd(input int q, input int v);
    rdptr_qid = QW'(q); rdptr_wdata = PW'(v); rdptr_we = 1'b1; tick; rdptr_we = 1'b0;
  endtask
  task automatic set_empty(input logic [31:0] w);
    empty_wdata = w; empty_we = 1'b1; tick; empty_we = 1'b0;
  endtask
  task automatic set_chen(input logic [7:0] w);
    chan_en_wdata = w; chan_en_we = 1'b1; tick; chan_en_we = 1'b0;
  endtask
  task automatic run_ready(input logic [7:0] m, input int n);
    req_ready = m; repeat (n) tick; req_ready = '0;
  endtask
  task automatic peek(input int q); rd_qid = QW'(q); #0.5; endtask

  function automatic int qid_of(input int c); return int'(req_qid[c*QW +: QW]); endfunction
  function automatic int idx_of(input int c); return int'(req_idx[c*PW +: PW]); endfunction

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    chan_en_we = 0; chan_en_wdata = '0; wrptr_we = 0; wrptr_qid = '0; wrptr_wdata = '0;
    rdptr_we = 0; rdptr_qid = '0; rdptr_wdata = '0; cfg_we = 0; cfg_qid = '0; cfg_wdata = '0;
    empty_we = 0; empty_wdata = '0; req_ready = '0; rd_qid = '0;
    repeat (3) tick;
    rst_n = 1'b1;
    repeat (3) tick;
    mon_on = 1'b1;

    // R1 reset state
    chk("R1 req_valid", int'(req_valid), 0);
    chk("R1 empty_flags", int'(empty_flags), 16'hFFFF);
    peek(7);
    chk("R1 rdptr", int'(rd_rdptr), 0);
    chk("R1 cfg", int'(rd_cfg), 0);

    // R2 masked configuration writes
    set_cfg(3, 20'hFFD22);             // full mask, value 0x122
    peek(3); chk("R2 full write", int'(rd_cfg), 'h122);
    set_cfg(3, 20'h00401 | 20'h00020); // set bit0 (masked), bit5 unmasked
    peek(3); chk("R2 masked write", int'(rd_cfg), 'h123);
    set_cfg(3, 20'h00400);             // clear bit0 only
    peek(3); chk("R2 clear one bit", int'(rd_cfg), 'h122);

    // R4 / R3 / R9: ring 1 on channel 2
    set_cfg(1, 20'hFFC05);
    set_wr(1, 3);
    chk("R9 flag after producer write", int'(empty_flags[1]), 0);
    chk("R4 disabled channel quiet", int'(req_valid[2]), 0);
    set_chen(8'hFF);
    chk("R3 valid", int'(req_valid[2]), 1);
    chk("R3 qid", qid_of(2), 1);
    chk("R3 idx", idx_of(2), 0);

    // R6 advances through the scoreboard
    push(2, 1, 0, "R6 step0"); push(2, 1, 1, "R6 step1"); push(2, 1, 2, "R6 step2");
    run_ready(8'h04, 3);
    peek(1); chk("R6 rdptr after three", int'(rd_rdptr), 3);
    chk("R9 drained empty", int'(empty_flags[1]), 1);
    chk("R3 drained no request", int'(req_valid[2]), 0);

    // R7 rotation on channel 0 among rings 5,6,7
    set_wr(5, 2); set_wr(6, 2); set_wr(7, 2);
    set_cfg(5, 20'hFFC01); set_cfg(6, 20'hFFC01); set_cfg(7, 20'hFFC01);
    chk("R7 first pick", qid_of(0), 5);
    push(0, 5, 0, "R7 a"); push(0, 6, 0, "R7 b"); push(0, 7, 0, "R7 c");
    push(0, 5, 1, "R7 d"); push(0, 6, 1, "R7 e"); push(0, 7, 1, "R7 f");
    run_ready(8'h01, 6);
    chk("R7 channel drained", int'(req_valid[0]), 0);

    // R8 two channels granted together
    set_wr(8, 1); set_wr(9, 1);
    set_cfg(8, 20'hFFC03); set_cfg(9, 20'hFFC07);
    chk("R8 both valid", int'(req_valid[1] && req_valid[3]), 1);
    push(1, 8, 0, "R8 ch1"); push(3, 9, 0, "R8 ch3");
    run_ready(8'h0A, 1);
    chk("R8 both drained", int'(req_valid[1] | req_valid[3]), 0);

    // R5 tracking mode needs window space
    set_wr(10, 1);
    set_cfg(10, 20'hFFD09);
    chk("R5 no window no request", int'(req_valid[4]), 0);
    set_cfg(10, 20'h08020);
    chk("R5 window opens request", int'(req_valid[4]), 1);

    // R11 channel field out of range
    set_wr(11, 1);
    set_cfg(11, 20'hFFC13);
    chk("R11 not empty", int'(empty_flags[11]), 0);
    chk("R11 no request anywhere", int'(req_valid & 8'hEF), 0);

    // R6 wrap 255 -> 0
    set_rd(12, 255); set_wr(12, 0);
    set_cfg(12, 20'hFFC0B);
    chk("R6 idx 255", idx_of(5), 255);
    push(5, 12, 255, "R6 wrap");
    run_ready(8'h20, 1);
    peek(12); chk("R6 wrapped rdptr", int'(rd_rdptr), 0);
    chk("R9 wrap empties", int'(empty_flags[12]), 1);
    chk("R6 no request after wrap", int'(req_valid[5]), 0);

    // R10 empty-flag masked writes
    set_wr(13, 4);
    set_cfg(13, 20'hFFC0D);
    chk("R10 before force", int'(req_valid[6]), 1);
    set_empty(32'h2000_2800);
    chk("R10 forced flag", int'(empty_flags[13]), 1);
    chk("R10 unmasked flag kept", int'(empty_flags[11]), 0);
    chk("R10 forced flag gates", int'(req_valid[6]), 0);
    set_empty(32'h2000_0000);
    chk("R10 flag cleared", int'(req_valid[6]), 1);

    // R12 host consumer write beats an advance
    push(6, 13, 0, "R12 grant");
    rdptr_qid = 4'd13; rdptr_wdata = 8'd2; rdptr_we = 1'b1; req_ready = 8'h40;
    tick;
    rdptr_we = 1'b0; req_ready = '0;
    peek(13); chk("R12 host value wins", int'(rd_rdptr), 2);
    chk("R12 request index", idx_of(6), 2);

    // R4 disabling a busy channel
    set_chen(8'hBF);
    chk("R4 channel turned off", int'(req_valid[6]), 0);
    chk("R4 other channel still on", int'(req_valid[4]), 1);

    repeat (2) tick;
    chk("R7 scoreboard empty", sb.size(), 0);
    finish_run();
  end
endmodule